// File: doc/BRIEF.md
# DMA Channel Interrupt Merger

This block gathers completion and overflow events from four DMA channels and turns them into interrupt requests. Each channel watches three event sources: the transfer count running out, the source-address window wrapping, and the destination-address window wrapping. Each source has its own enable. Any enabled event latches one sticky request flag for its channel. The flag does not record which source raised it.

A master enable for each channel gates that flag onto the channel's interrupt line. The line is a level: it stays high for as long as both the flag and the master enable are 1. A fixed-priority resolver then reports which pending channel ranks highest. Channel 0 ranks first and channel 3 last.

Software uses a single write port to program the enables and to clear the flags. Each write carries one channel's whole configuration word.

Top module: `dma_irq_merge`

## Requirements
- R1: The reset (`rst_n` low) clears every source enable, every master enable and every request flag. While in reset and after it, `irq`, `irq_valid` and `irq_idx` read 0. With the source enables still cleared, events raise nothing.
- R2: A write with `wr_en`=1 goes to the channel selected by `wr_addr`. `wr_data` bit 0 enables the transfer-count event. Bit 1 enables the source-wrap event. Bit 2 enables the destination-wrap event. Bit 3 is the master enable. Bit 4 is the flag write bit. An event pulse on a source whose enable is 1 sets the channel's flag.
- R3: An event on a disabled source is dropped. It is not remembered, so enabling that source later raises no request.
- R4: The three sources of a channel share one flag. The flag stays set until it is cleared, and a single clear removes it whichever source set it.
- R5: Writing 0 to flag bit 4 clears the flag. Writing 1 to bit 4 leaves the flag unchanged.
- R6: If a clear write and an enabled event reach the same channel in the same cycle, the flag ends up set.
- R7: `irq[n]` is 1 exactly when channel n's master enable is 1 and its flag is 1. If the master enable is dropped and then raised again while the flag is still set, the request comes back.
- R8: `irq_valid` is the OR of `irq`. `irq_idx` gives the lowest-numbered channel whose `irq` bit is 1, and it reads 0 when no channel is pending. Both follow `irq` with no added delay.
- R9: A write changes only the channel that `wr_addr` selects.
- R10: A flag set or cleared at a clock edge shows on `irq` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_tc | input | 4 | Transfer-count-done pulse, one bit per channel |
| evt_sov | input | 4 | Source-address wrap pulse, one bit per channel |
| evt_dov | input | 4 | Destination-address wrap pulse, one bit per channel |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Channel selected by the write |
| wr_data | input | 5 | Source enables [2:0], master enable [3], flag write [4] |
| irq | output | 4 | Per-channel interrupt request level |
| irq_valid | output | 1 | At least one channel is requesting |
| irq_idx | output | 2 | Highest-priority requesting channel |

## Verification
A wrong source enable or flag is visible on `irq` one edge after the event or the write that exposes it. A lost or phantom flag is seen the same way, but only while the channel's master enable is 1, so the bench keeps master enables on during event steps. A wrong priority decision shows on `irq_idx` in the same cycle as the `irq` pattern that causes it. A bench model follows every write and event pulse and compares all three outputs after every edge.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int EV_NUM   = 3;
  localparam int CFG_W    = 5;
  localparam int BIT_TC   = 0;
  localparam int BIT_SOV  = 1;
  localparam int BIT_DOV  = 2;
  localparam int BIT_MEN  = 3;
  localparam int BIT_FLAG = 4;

  typedef struct packed {
    logic              men;
    logic [EV_NUM-1:0] src_en;
  } chan_cfg_t;
endpackage

// File: rtl/dirq_dec.sv
module dirq_dec #(
  parameter int NCH = 4,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  output logic [NCH-1:0] sel_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign sel_o[g] = wr_en && (wr_addr == AW'(g));
  end
endmodule

// File: rtl/dirq_chan.sv
module dirq_chan
  import dirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_NUM-1:0] evt_i,
  input  logic              we_i,
  input  logic [CFG_W-1:0]  data_i,
  output logic              irq_o
);
  chan_cfg_t cfg_q, cfg_d;
  logic      flag_q, flag_d;
  logic      set_hit, clr_hit;

  always_comb begin
    set_hit    = |(evt_i & cfg_q.src_en);
    clr_hit    = we_i && !data_i[BIT_FLAG];
    flag_d     = set_hit || (flag_q && !clr_hit);
    cfg_d.men  = data_i[BIT_MEN];
    cfg_d.src_en = {data_i[BIT_DOV], data_i[BIT_SOV], data_i[BIT_TC]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign irq_o = flag_q && cfg_q.men;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & cfg_q.src_en)) |=> flag_q); // R2
  AST_NO_PHANTOM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !(|(evt_i & cfg_q.src_en))) |=> !flag_q); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !we_i) |=> flag_q); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !data_i[BIT_FLAG] && !(|(evt_i & cfg_q.src_en))) |=> !flag_q); // R5
endmodule

// File: rtl/dirq_prio.sv
module dirq_prio #(
  parameter int NCH = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req_i,
  output logic            valid_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i);
    end
    valid_o = |req_i;
  end

  AST_IDX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[idx_o]); // R8
  AST_IDX_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((req_i & ((NCH'(1) << idx_o) - NCH'(1))) == '0)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> (!valid_o && idx_o == '0)); // R8
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
  import dirq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   evt_tc,
  input  logic [NCH-1:0]   evt_sov,
  input  logic [NCH-1:0]   evt_dov,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  output logic [NCH-1:0]   irq,
  output logic             irq_valid,
  output logic [AW-1:0]    irq_idx
);
  logic [NCH-1:0] sel;

  dirq_dec #(.NCH(NCH)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .sel_o  (sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dirq_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i ({evt_dov[g], evt_sov[g], evt_tc[g]}),
      .we_i  (sel[g]),
      .data_i(wr_data),
      .irq_o (irq[g])
    );
  end

  dirq_prio #(.NCH(NCH)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq),
    .valid_o(irq_valid),
    .idx_o  (irq_idx)
  );

  AST_ONEHOT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R9
endmodule

// File: tb/test_dma_irq_merge.sv
module test_dma_irq_merge;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] evt_tc, evt_sov, evt_dov;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [4:0] wr_data;
  logic [3:0] irq;
  logic       irq_valid;
  logic [1:0] irq_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [3:0] irq;
    logic       v;
    logic [1:0] idx;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [3:0] m_en [4];
  logic       m_flag [4];

  dma_irq_merge i_dma_irq_merge (
    .clk(clk), .rst_n(rst_n), .evt_tc(evt_tc), .evt_sov(evt_sov), .evt_dov(evt_dov),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  always #10 clk = ~clk;

  task automatic check(input logic [3:0] ai, input logic av, input logic [1:0] ax,
                       input logic [3:0] ei, input logic ev, input logic [1:0] ex,
                       input string tag);
    n_chk++;
    if (ai !== ei || av !== ev || ax !== ex) begin
      n_bad++;
      $display("FAIL %s: irq=%b valid=%b idx=%0d expected irq=%b valid=%b idx=%0d",
               tag, ai, av, ax, ei, ev, ex);
    end
  endtask

  task automatic drive(input logic [3:0] tc, input logic [3:0] sov, input logic [3:0] dov,
                       input logic we, input logic [1:0] a, input logic [4:0] d,
                       input string tag);
    exp_t e;
    @(negedge clk);
    evt_tc = tc; evt_sov = sov; evt_dov = dov;
    wr_en = we; wr_addr = a; wr_data = d;
    for (int c = 0; c < 4; c++) begin
      logic s;
      s = |({dov[c], sov[c], tc[c]} & m_en[c][2:0]);
      if (we && a == 2'(c)) begin
        if (!d[4]) m_flag[c] = 1'b0;
        m_en[c] = d[3:0];
      end
      if (s) m_flag[c] = 1'b1;
    end
    e.irq = '0;
    for (int c = 0; c < 4; c++) e.irq[c] = m_flag[c] && m_en[c][3];
    e.v = |e.irq;
    e.idx = 2'd0;
    for (int c = 3; c >= 0; c--) if (e.irq[c]) e.idx = 2'(c);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(4'h0, 4'h0, 4'h0, 1'b0, 2'd0, 5'h00, tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(irq, irq_valid, irq_idx, e.irq, e.v, e.idx, e.tag);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_en[c] = '0; m_flag[c] = 1'b0; end
    rst_n = 1'b0;
    evt_tc = '0; evt_sov = '0; evt_dov = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #5 check(irq, irq_valid, irq_idx, 4'h0, 1'b0, 2'd0, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    // R1: master on, sources still disabled after reset
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd0, 5'b1_1000, "R1 master only ch0");
    drive(4'hF, 4'hF, 4'hF, 1'b0, 2'd0, 5'h00, "R1 events with sources off");
    idle("R1 idle");
    // R2/R10 transfer-count source on ch1
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b1_1001, "R9 write ch1 only");
    drive(4'h2, 4'h0, 4'h0, 1'b0, 2'd0, 5'h00, "R2 R10 tc event ch1");
    idle("R4 flag holds");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b0_1001, "R5 clear ch1");
    // R3 disabled source dropped, not remembered
    drive(4'h0, 4'h2, 4'h0, 1'b0, 2'd0, 5'h00, "R3 sov disabled ch1");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b1_1011, "R3 enable sov later");
    idle("R3 nothing remembered");
    // R4 a different source sets same flag
    drive(4'h0, 4'h2, 4'h0, 1'b0, 2'd0, 5'h00, "R4 sov event ch1");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b1_1011, "R5 write one keeps flag");
    drive(4'h2, 4'h2, 4'h0, 1'b0, 2'd0, 5'h00, "R4 two sources one flag");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b0_1011, "R4 single clear");
    drive(4'h0, 4'h2, 4'h0, 1'b0, 2'd0, 5'h00, "R4 re-set ch1");
    // R6 set wins
    drive(4'h2, 4'h0, 4'h0, 1'b1, 2'd1, 5'b0_1011, "R6 set beats clear");
    // R7 level and reassert
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b1_0011, "R7 master off");
    idle("R7 masked");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b1_1011, "R7 master back on");
    // R8 priority
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd2, 5'b1_1111, "R9 enable ch2");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd3, 5'b1_1100, "R9 enable ch3");
    drive(4'h0, 4'h0, 4'hC, 1'b0, 2'd0, 5'h00, "R8 ch1 ch2 ch3 pending");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd1, 5'b0_1011, "R8 clear ch1");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd2, 5'b0_1111, "R8 clear ch2");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd0, 5'b1_1100, "R9 ch0 dov enable");
    drive(4'h0, 4'h0, 4'h1, 1'b0, 2'd0, 5'h00, "R8 ch0 wins");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd3, 5'b0_1100, "R9 clear ch3 only");
    drive(4'h0, 4'h0, 4'h0, 1'b1, 2'd0, 5'b0_1100, "R8 all clear");
    idle("R8 idle zero");
    @(negedge clk);
    repeat (3) @(posedge clk);
    #8;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule